// File: doc/BRIEF.md
# Address-Line Scanline Interrupt Counter

This block sits on the cartridge side of a video system. It counts scanlines by watching bit 12 of the video chip's address bus and raises an interrupt to the CPU once a programmed number of lines has gone by. During each line the video fetch engine moves that address bit between the low and high pattern halves. A rising edge of the bit advances an 8-bit down-counter, but only when the bit has first stayed low for long enough. Because of this filter, a burst of closely spaced edges, such as the sprite-pattern fetches late in a line, advances the counter only once.

Software uses four write-only register functions. It can set the value loaded on a reload, force a reload at the next counted edge, turn the interrupt off (this also withdraws a pending request) and turn the interrupt on. The request is a level. It stays high until software turns the interrupt off. All logic runs on the dot clock. Register writes arrive as a one-cycle strobe in that same domain.

Top module: `scanline_irq_ctr`

## Requirements
- R1: After reset `irq_o` is low, the counter, reload value, pending-reload flag and enable are zero, and the low-time timer starts saturated, so the first rising edge after reset is counted however briefly `pa12` was low.
- R2: A rising edge of `pa12` is counted only if `pa12` was sampled low on at least LOW_MIN+1 (default 17) consecutive clock edges just before it. The low-time count clears whenever `pa12` is sampled high.
- R3: On a counted edge the counter loads the reload value if it is zero or a reload is pending. Otherwise it decrements by one.
- R4: A write with `reg_sel`=2'b00 latches `reg_wdata` as the reload value. The latched value is used by later reloads without any further request.
- R5: A write with `reg_sel`=2'b01 sets a pending-reload flag. The next counted edge then reloads the counter even when it is nonzero, and clears the flag.
- R6: A write with `reg_sel`=2'b11 enables the interrupt. A write with `reg_sel`=2'b10 disables it and drops `irq_o` on the next clock. While disabled, reaching zero raises nothing.
- R7: `irq_o` rises on the clock edge of a counted edge that takes the counter from nonzero to zero while enabled. A reload of zero onto a counter that is already zero raises nothing.
- R8: Once raised, `irq_o` stays high through further edges and enable writes until a `reg_sel`=2'b10 write.
- R9: Eight rising edges 8 clocks apart (4 low, 4 high), the first preceded by a long low time, advance the counter exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | One-cycle register write strobe |
| reg_sel | input | 2 | Function select: bit 1 picks counter (0) or interrupt (1) group, bit 0 the even/odd function |
| reg_wdata | input | 8 | Write data (used by the reload-value function) |
| pa12 | input | 1 | Video address bus bit 12 |
| irq_o | output | 1 | Level interrupt request, active high |

## Verification
The bench sweeps the low time before an edge across the filter threshold. A filter that is off by one would count a 16-dot gap or drop a 17-dot gap, and a filter that only looks at edge spacing would count the short sprite-fetch edges as extra lines. For reload values from 1 to 6 it sweeps the number of edges and expects the interrupt exactly on edge N+1. A design that decrements on the reload edge, or that fires on reload, would move that edge by one. It also checks a zero-onto-zero reload, which a design without the nonzero-before condition would signal. Finally it checks that enable writes do not clear a raised request.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  // reg_sel[1] picks the group, reg_sel[0] the even/odd function
  typedef enum logic [1:0] {
    FN_RELOAD_VAL = 2'b00,
    FN_RELOAD_REQ = 2'b01,
    FN_IRQ_OFF    = 2'b10,
    FN_IRQ_ON     = 2'b11
  } reg_fn_e;
endpackage

// File: rtl/a12_edge_filter.sv
module a12_edge_filter #(
  parameter int LOW_MIN = 16,
  parameter int TMR_W   = $clog2(LOW_MIN + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pa12,
  output logic tick
);
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};
  localparam logic [TMR_W-1:0] TMR_MIN = TMR_W'(LOW_MIN);

  logic             pa12_q;
  logic [TMR_W-1:0] low_q, low_n;

  always_comb begin
    if (pa12)                 low_n = '0;
    else if (low_q == TMR_MAX) low_n = low_q;
    else                      low_n = low_q + 1'b1;
  end

  // edge counts only after a long enough low stretch (R2)
  assign tick = pa12 && !pa12_q && (low_q > TMR_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa12_q <= 1'b1;
      low_q  <= TMR_MAX;   // saturated so first edge counts (R1)
    end else begin
      pa12_q <= pa12;
      low_q  <= low_n;
    end
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import scanline_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] reload_val,
  output logic             irq_en,
  output logic             req_stb,
  output logic             off_stb
);
  logic             val_we, on_stb;
  logic [CNT_W-1:0] reload_n;
  logic             en_n;

  always_comb begin
    val_we  = wr_en && (reg_fn_e'(sel) == FN_RELOAD_VAL);
    req_stb = wr_en && (reg_fn_e'(sel) == FN_RELOAD_REQ);
    off_stb = wr_en && (reg_fn_e'(sel) == FN_IRQ_OFF);
    on_stb  = wr_en && (reg_fn_e'(sel) == FN_IRQ_ON);
    reload_n = val_we ? wdata : reload_val;
    en_n = irq_en;
    if (on_stb)  en_n = 1'b1;
    if (off_stb) en_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_val <= '0;
      irq_en     <= 1'b0;
    end else begin
      reload_val <= reload_n;
      irq_en     <= en_n;
    end
  end
endmodule

// File: rtl/line_down_counter.sv
module line_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             req_stb,
  input  logic             off_stb,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  logic             pend_q, pend_n, irq_n;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n  = cnt;
    pend_n = pend_q;
    irq_n  = irq;
    if (tick) begin
      if ((cnt == '0) || pend_q) begin
        cnt_n  = reload_val;
        pend_n = 1'b0;
      end else begin
        cnt_n = cnt - 1'b1;
      end
      if ((cnt != '0) && (cnt_n == '0) && irq_en) irq_n = 1'b1;
    end
    if (req_stb) pend_n = 1'b1;
    if (off_stb) irq_n  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      pend_q <= pend_n;
      irq    <= irq_n;
    end
  end
endmodule

// File: rtl/scanline_irq_ctr.sv
module scanline_irq_ctr #(
  parameter int CNT_W   = 8,
  parameter int LOW_MIN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             pa12,
  output logic             irq_o
);
  localparam int TMR_W = $clog2(LOW_MIN + 2);

  logic             tick, irq_en, req_stb, off_stb;
  logic [CNT_W-1:0] reload_val, cnt;

  a12_edge_filter #(.LOW_MIN(LOW_MIN), .TMR_W(TMR_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .pa12(pa12), .tick(tick)
  );

  irq_reg_port #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
    .wdata(reg_wdata), .reload_val(reload_val), .irq_en(irq_en),
    .req_stb(req_stb), .off_stb(off_stb)
  );

  line_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload_val(reload_val),
    .req_stb(req_stb), .off_stb(off_stb), .irq_en(irq_en),
    .cnt(cnt), .irq(irq_o)
  );
endmodule

// File: rtl/scanline_irq_ctr_chk.sv
module scanline_irq_ctr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [1:0]       reg_sel,
  input logic             pa12,
  input logic             irq_o,
  input logic             tick,
  input logic             irq_en,
  input logic [CNT_W-1:0] cnt
);
  assert_tick_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (pa12 && !$past(pa12)));

  assert_cnt_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_off_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_sel == 2'b10) |=> !irq_o);

  assert_irq_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (cnt == '0) && $past(irq_en));

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(reg_wr_en && reg_sel == 2'b10)) |=> irq_o);
endmodule

bind scanline_irq_ctr scanline_irq_ctr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
  .pa12(pa12), .irq_o(irq_o), .tick(tick), .irq_en(irq_en), .cnt(cnt)
);

// File: tb/scanline_irq_ctr_tb_top.sv
`timescale 1ns/1ps
module scanline_irq_ctr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_sel = 2'b00;
  logic [7:0] reg_wdata = 8'h00;
  logic       pa12 = 1'b0;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  scanline_irq_ctr dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .pa12(pa12), .irq_o(irq_o)
  );

  task automatic chk(input string req, input bit exp);
    total++;
    if (irq_o !== exp) begin
      bad++;
      $display("FAIL %s: irq_o=%0b expected=%0b at %0t", req, irq_o, exp, $time);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    @(negedge clk);
  endtask

  // pa12 sampled low on 'lo' edges, then high on 'hi' edges
  task automatic edge_a12(input int lo, input int hi);
    pa12 = 1'b0;
    repeat (lo) @(negedge clk);
    pa12 = 1'b1;
    repeat (hi) @(negedge clk);
    pa12 = 1'b0;
  endtask

  task automatic rearm();
    wr(2'b10, 8'h00);
    wr(2'b11, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset irq low", 1'b0);

    // R1: first edge after reset counts despite short low time
    wr(2'b00, 8'd1);
    wr(2'b11, 8'h00);
    edge_a12(1, 4);          // counted: 0 -> reload 1
    chk("R1 first edge reload", 1'b0);
    edge_a12(20, 4);         // 1 -> 0
    chk("R1 saturated timer first edge", 1'b1);

    // R8: hold through edges, enable writes
    repeat (40) @(negedge clk);
    chk("R8 hold idle", 1'b1);
    edge_a12(20, 4);
    wr(2'b11, 8'h00);
    chk("R8 hold after edge and enable", 1'b1);
    wr(2'b10, 8'h00);
    chk("R6 disable clears irq", 1'b0);

    // R3/R7 sweep: reload N, fire on edge N+1
    wr(2'b11, 8'h00);
    for (int n = 1; n <= 6; n++) begin
      rearm();
      wr(2'b00, 8'(n));
      wr(2'b01, 8'h00);
      edge_a12(20, 4);
      chk($sformatf("R3 reload edge n=%0d", n), 1'b0);
      for (int k = 1; k <= n; k++) begin
        edge_a12(20, 4);
        chk($sformatf("R7 n=%0d k=%0d", n, k), (k == n));
      end
    end

    // R2 filter sweep across threshold
    wr(2'b00, 8'd1);
    for (int l = 8; l <= 24; l++) begin
      rearm();
      wr(2'b01, 8'h00);
      edge_a12(20, 4);       // cnt = 1
      edge_a12(l, 4);
      chk($sformatf("R2 low=%0d", l), (l >= 17));
    end

    // R9 burst of sprite-fetch edges counts once
    rearm();
    wr(2'b00, 8'd2);
    wr(2'b01, 8'h00);
    edge_a12(20, 4);         // cnt = 2
    edge_a12(20, 4);         // burst start: cnt = 1
    for (int b = 0; b < 7; b++) edge_a12(4, 4);
    chk("R9 burst counted once", 1'b0);
    edge_a12(20, 4);         // cnt = 0
    chk("R9 next line fires", 1'b1);

    // R7 zero reload onto zero counter
    rearm();
    wr(2'b00, 8'd0);
    wr(2'b01, 8'h00);
    edge_a12(20, 4);
    chk("R7 zero onto zero", 1'b0);
    edge_a12(20, 4);
    chk("R7 zero reload repeat", 1'b0);

    // R4 latched value used on zero reload without request
    wr(2'b00, 8'd3);
    edge_a12(20, 4);         // 0 -> 3
    chk("R4 reload to 3", 1'b0);
    edge_a12(20, 4);
    edge_a12(20, 4);
    chk("R4 at 1", 1'b0);
    edge_a12(20, 4);
    chk("R4 fires after 3", 1'b1);

    // R5 request reloads a nonzero counter
    rearm();
    wr(2'b00, 8'd5);
    wr(2'b01, 8'h00);
    edge_a12(20, 4);         // 5
    edge_a12(20, 4);         // 4
    edge_a12(20, 4);         // 3
    wr(2'b00, 8'd1);
    wr(2'b01, 8'h00);
    edge_a12(20, 4);         // forced reload -> 1
    chk("R5 forced reload", 1'b0);
    edge_a12(20, 4);         // 0
    chk("R5 fires after forced reload", 1'b1);

    // R6 disabled: reaching zero raises nothing
    wr(2'b10, 8'h00);
    wr(2'b01, 8'h00);
    edge_a12(20, 4);         // 1
    edge_a12(20, 4);         // 0
    chk("R6 disabled no irq", 1'b0);
    wr(2'b11, 8'h00);
    chk("R6 enable not retroactive", 1'b0);
    edge_a12(20, 4);         // 0 -> reload 1
    edge_a12(20, 4);         // 0
    chk("R6 enabled fires", 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule